// File: doc/BRIEF.md
# Erased Page Zero-Bit Detector

This block is called when a sector's error decoder has given up with more than eight errors. It checks whether the sector is simply an erased page. Erased flash reads back as all ones, but the stored check bytes of an erased page are also all ones, and they do not match the check code computed from all-ones data. The block takes the sector as one byte stream: the data bytes first, then the stored check bytes. In each region it counts the bits that read as zero, and each count stops rising once it is past the limit. If the two counts together stay within the limit, the sector is treated as erased. The data zero count is then reported as the number of corrected bits. If that count is nonzero, the block writes 0xFF to every data byte through its buffer write port.

If the combined count is past the limit, the block reports the sector as uncorrectable. Results are valid together with a one-cycle `done` pulse and are held until the next accepted `start`. Any buffer rewrite has finished before `done` is raised.

Top module: `erased_sector_detect`

## Requirements
- R1: After reset, `done`, `wr_en`, `erased`, `uncorrectable` and `corr_bits` are all 0.
- R2: After an accepted `start`, the first DATA_BYTES bytes taken with `in_valid` high form the data region and the next ECC_BYTES bytes form the check region. The zero count of a byte is the number of 0 bits in it.
- R3: Each region's count saturates at LIMIT+1. A region with far more zero bits than the limit (for example all 0x00) therefore never wraps to a small value, and the sector is reported uncorrectable.
- R4: When the data zero count plus the check zero count is at most LIMIT, `done` comes with `erased`=1, `uncorrectable`=0 and `corr_bits` equal to the data zero count.
- R5: In the erased case with a nonzero data zero count, the block drives `wr_en` for DATA_BYTES consecutive cycles. Each of these cycles writes `wr_data`=0xFF, at addresses 0 up to DATA_BYTES-1 in ascending order. `done` rises in the cycle after the last write.
- R6: In the erased case with a data zero count of zero, no write is made.
- R7: When the combined count exceeds LIMIT, `done` comes with `uncorrectable`=1, `erased`=0 and `corr_bits`=0, and no write is made.
- R8: `done` lasts one cycle per sector. `erased`, `uncorrectable` and `corr_bits` hold their values until the next accepted `start`.
- R9: `start` has no effect while a sector is being received, evaluated or rewritten. Bytes presented with `in_valid` while the block is idle are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new sector check when idle |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector byte stream: data region, then check region |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(DATA_BYTES) | Buffer byte address |
| wr_data | output | 8 | Buffer write value (0xFF) |
| done | output | 1 | One-cycle result strobe |
| erased | output | 1 | Sector judged to be an erased page |
| uncorrectable | output | 1 | Sector judged uncorrectable |
| corr_bits | output | $clog2(LIMIT+2) | Data zero count reported as corrected bits |

## Verification
The sweep crosses data zero counts from 0 to 12 and all-zero data with check zero counts from 0 to 4 and all-zero check bytes. Every case's result is computed arithmetically, and the bench checks it together with a model of the buffer that applies each observed write. Two events are made to fall on the same cycle. In one case a `start` is pulsed while the buffer rewrite is running; the bench judges it by requiring exactly one `done`, a full ordered rewrite, and unchanged held results. In the other case stray zero-filled bytes are streamed while the block is idle, followed by a clean sector, which must still report erased with zero corrected bits.

// File: rtl/erased_sector_detect.sv
module erased_sector_detect #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int LIMIT      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          in_valid,
  input  logic [7:0]                    in_byte,
  output logic                          wr_en,
  output logic [$clog2(DATA_BYTES)-1:0] wr_addr,
  output logic [7:0]                    wr_data,
  output logic                          done,
  output logic                          erased,
  output logic                          uncorrectable,
  output logic [$clog2(LIMIT+2)-1:0]    corr_bits
);
  localparam int TOTAL = DATA_BYTES + ECC_BYTES;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam int AW    = $clog2(DATA_BYTES);
  localparam int CW    = $clog2(LIMIT + 2);
  localparam int SW    = CW + 4;
  localparam int SAT   = LIMIT + 1;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_EVAL, S_FILL} state_t;

  state_t          state;
  logic [IW-1:0]   idx;
  logic [AW-1:0]   faddr;
  logic [CW-1:0]   dcnt, ecnt;
  logic [3:0]      zeros;
  logic [CW:0]     total;
  logic            in_data;

  assign zeros   = 4'($countones(~in_byte));
  assign total   = {1'b0, dcnt} + {1'b0, ecnt};
  assign in_data = idx < IW'(DATA_BYTES);
  assign wr_en   = (state == S_FILL);
  assign wr_addr = faddr;
  assign wr_data = 8'hFF;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] c, input logic [3:0] z);
    logic [SW-1:0] s;
    s = SW'(c) + SW'(z);
    return (s > SW'(SAT)) ? CW'(SAT) : s[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      faddr <= '0;
      dcnt <= '0;
      ecnt <= '0;
      done <= 1'b0;
      erased <= 1'b0;
      uncorrectable <= 1'b0;
      corr_bits <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RECV;
          idx <= '0;
          dcnt <= '0;
          ecnt <= '0;
          erased <= 1'b0;
          uncorrectable <= 1'b0;
          corr_bits <= '0;
        end
        S_RECV: if (in_valid) begin
          if (in_data) dcnt <= sat_add(dcnt, zeros);
          else         ecnt <= sat_add(ecnt, zeros);
          idx <= idx + 1'b1;
          if (idx == IW'(TOTAL - 1)) state <= S_EVAL;
        end
        S_EVAL: begin
          if (total <= (CW+1)'(LIMIT)) begin
            if (dcnt != '0) begin
              state <= S_FILL;
              faddr <= '0;
            end else begin
              state <= S_IDLE;
              done <= 1'b1;
              erased <= 1'b1;
              corr_bits <= '0;
            end
          end else begin
            state <= S_IDLE;
            done <= 1'b1;
            uncorrectable <= 1'b1;
          end
        end
        S_FILL: begin
          if (faddr == AW'(DATA_BYTES - 1)) begin
            state <= S_IDLE;
            done <= 1'b1;
            erased <= 1'b1;
            corr_bits <= dcnt;
          end else begin
            faddr <= faddr + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt <= CW'(SAT)) && (ecnt <= CW'(SAT)));

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (erased != uncorrectable));

  a_r4_corr_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (done && erased) |-> (corr_bits <= CW'(LIMIT)));

  a_r5_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!wr_en || wr_addr == $past(wr_addr) + 1'b1));

  a_r6_no_write_before_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && erased && corr_bits == '0) |-> !$past(wr_en));

  a_r7_no_write_before_uncorrectable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> !$past(wr_en));
endmodule

// File: tb/tb_erased_sector_detect.sv
module tb_erased_sector_detect;
  localparam int DB = 8;
  localparam int EB = 2;
  localparam int LIM = 8;
  localparam int AW = $clog2(DB);
  localparam int CW = $clog2(LIM + 2);

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [7:0] in_byte = 8'hFF;
  logic wr_en, done, erased, uncorrectable;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [CW-1:0] corr_bits;

  erased_sector_detect #(.DATA_BYTES(DB), .ECC_BYTES(EB), .LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .erased(erased), .uncorrectable(uncorrectable), .corr_bits(corr_bits));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int done_cnt, wr_cnt, exp_addr, order_err;
  int cap_er, cap_un, cap_corr;
  logic [7:0] dat [DB];
  logic [7:0] ecc [EB];
  logic [7:0] mem [DB];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      mem[wr_addr] = wr_data;
      if (int'(wr_addr) != exp_addr) order_err++;
      exp_addr++;
      wr_cnt++;
    end
    if (rst_n && done) begin
      done_cnt++;
      cap_er = int'(erased);
      cap_un = int'(uncorrectable);
      cap_corr = int'(corr_bits);
    end
  end

  task automatic run(input int dz, input int ez, input bit poke);
    int ok_mem;
    bit ex_er;
    for (int i = 0; i < DB; i++) dat[i] = 8'hFF;
    for (int i = 0; i < EB; i++) ecc[i] = 8'hFF;
    for (int i = 0; i < dz && i < DB*8; i++) dat[i % DB][i / DB] = 1'b0;
    for (int i = 0; i < ez && i < EB*8; i++) ecc[i % EB][i / EB] = 1'b0;
    for (int i = 0; i < DB; i++) mem[i] = dat[i];
    done_cnt = 0; wr_cnt = 0; exp_addr = 0; order_err = 0;
    @(posedge clk) #1 start = 1;
    @(posedge clk) #1 start = 0; in_valid = 1;
    for (int i = 0; i < DB + EB; i++) begin
      in_byte = (i < DB) ? dat[i] : ecc[i - DB];
      @(posedge clk) #1;
    end
    in_valid = 0; in_byte = 8'hFF;
    for (int c = 0; c < 2*DB + 20; c++) begin
      start = (poke && c == 3);
      @(posedge clk) #1;
    end
    start = 0;
    ex_er = (dz + ez) <= LIM;
    chk("R8 one done pulse", done_cnt, 1);
    chk("R4 erased flag", cap_er, int'(ex_er));
    chk("R7 uncorrectable flag", cap_un, int'(!ex_er));
    chk("R2 corrected bit count", cap_corr, ex_er ? dz : 0);
    if (dz > LIM || ez > LIM) chk("R3 saturated region uncorrectable", cap_un, 1);
    if (ex_er && dz > 0) begin
      chk("R5 write count", wr_cnt, DB);
      chk("R5 write order", order_err, 0);
    end else if (ex_er) chk("R6 no writes when clean", wr_cnt, 0);
    else chk("R7 no writes when uncorrectable", wr_cnt, 0);
    ok_mem = 1;
    for (int i = 0; i < DB; i++)
      if (mem[i] != ((ex_er && dz > 0) ? 8'hFF : dat[i])) ok_mem = 0;
    chk("R5 buffer contents", ok_mem, 1);
    chk("R8 erased held", int'(erased), cap_er);
    chk("R8 uncorrectable held", int'(uncorrectable), cap_un);
    chk("R8 count held", int'(corr_bits), cap_corr);
    if (poke) chk("R9 start during rewrite ignored", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 wr_en at reset", int'(wr_en), 0);
    chk("R1 erased at reset", int'(erased), 0);
    chk("R1 uncorrectable at reset", int'(uncorrectable), 0);
    chk("R1 count at reset", int'(corr_bits), 0);

    for (int d = 0; d <= 13; d++) begin
      for (int e = 0; e <= 5; e++) begin
        run((d == 13) ? DB*8 : d, (e == 5) ? EB*8 : e, 1'b0);
      end
    end

    run(1, 0, 1'b1);
    run(5, 3, 1'b1);

    @(posedge clk) #1 in_valid = 1; in_byte = 8'h00;
    repeat (5) @(posedge clk);
    #1 in_valid = 0; in_byte = 8'hFF;
    run(0, 0, 1'b0);
    chk("R9 idle bytes not counted", cap_corr, 0);
    chk("R9 idle bytes leave sector erased", cap_er, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule